// File: doc/BRIEF.md
# Scatter-Gather Table Walker with Byte Limit

This block takes one command's descriptor table and turns it into a stream of address/length segments for a data mover. Each table entry holds a base address and a size field. The size field counts from zero. The walker fetches entries one at a time over a simple request/response port. It skips the bytes in front of a starting byte offset, then emits segments until the requested transfer size is covered. No segment ever runs past that size. A table that describes more bytes than the transfer is normal, and the walker simply truncates it without reporting an error.

The transfer size comes from one of two sources. It can be given directly in bytes, and an all-ones value then means "no limit". It can also be given as a queued-command sector count, built from a high byte and a low byte, and scaled by 512. When the walk ends, the block pulses `done` and reports three results:

- the number of bytes prepared;
- an error code;
- a flag that tells the caller the table was shorter than the transfer.

Top module: `sg_walker`

## Requirements
- R1: The length of an entry is the low `SZ_W` bits of its size field plus one. Bits of the size field above `SZ_W` have no effect on any output.
- R2: The walk starts in the first entry whose end is strictly greater than the offset, where the end is the sum of all earlier lengths plus the entry's own length. The position inside that entry is the offset minus the sum of all earlier lengths.
- R3: The first segment's address is the entry address plus the in-entry position. Its length is the smaller of the bytes left in that entry and the limit.
- R4: Every later segment's length is the smaller of the entry length and the limit minus the bytes already emitted. Every segment length is nonzero. Once the emitted total equals the limit, no further entry is read.
- R5: When the table runs out before the limit is reached, `done` reports `err_code` 0 and `short_tbl` = 1, and `total_bytes` holds the bytes emitted. `short_tbl` is 0 whenever `err_code` is nonzero.
- R6: In byte mode, a `byte_limit` of all ones means unlimited. The walk then covers the whole table from the offset, and `short_tbl` = 0.
- R7: When `use_sectors` = 1, the limit is {`sect_hi`,`sect_lo`} × 512 and `byte_limit` is ignored.
- R8: If emitting a segment would raise the total above 2^31−1, that segment is not emitted. The walk ends with `err_code` 2 and `total_bytes` equal to the bytes emitted before it.
- R9: If no starting entry exists (the offset is at or beyond the table's byte sum, or the count is 0), the walk emits no segment and ends with `err_code` 1.
- R10: Entries are read in index order 0, 1, 2, … with `rd_req` high for one cycle per read. No new read is issued before the previous response has arrived, and no segment is offered while a read is outstanding.
- R11: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` hold steady.
- R12: A limit of 0 (not unlimited) ends the walk with no read, no segment, `err_code` 0 and `total_bytes` 0.
- R13: `done` is a one-cycle pulse. A `start` that arrives while a walk is in progress is ignored. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk; accepted only when idle |
| ent_count | input | CNT_W | Number of table entries |
| start_offset | input | LIM_W | Byte offset into the described buffer |
| byte_limit | input | LIM_W | Byte limit; all ones = unlimited |
| use_sectors | input | 1 | Take the limit from the sector count |
| sect_hi | input | SEC_W | Sector count, high byte |
| sect_lo | input | SEC_W | Sector count, low byte |
| rd_req | output | 1 | One-cycle entry read request |
| rd_idx | output | CNT_W | Index of the requested entry |
| rd_rsp_valid | input | 1 | Entry response strobe |
| rd_rsp_addr | input | AW | Entry base address |
| rd_rsp_size | input | FLD_W | Raw entry size field (zero-based) |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | AW | Segment start address |
| seg_len | output | SZ_W+1 | Segment length in bytes |
| done | output | 1 | Walk finished (pulse) |
| err_code | output | 2 | 0 none, 1 no starting entry, 2 total overflow |
| total_bytes | output | LIM_W | Bytes emitted |
| short_tbl | output | 1 | Table ended before the limit |

## Verification
The bench targets several corner cases, and each one catches a specific kind of defect:

- An offset that lands exactly on an entry boundary catches a `>=`/`>` slip in start-entry selection. That slip starts a zero-length piece in the wrong entry.
- A limit that ends inside an entry catches missing clipping. A walker without clipping emits the whole entry and reads past the end.
- A run of 600 maximum-size entries catches a design that emits the segment crossing 2^31 or never reports the overflow.
- Size fields with garbage in their upper bits catch a missing mask.
- Offsets past the end, a zero count and a zero limit check that no reads occur, no segments are emitted, and the error code is correct.
- A second `start` issued mid-walk checks that the running command is not disturbed.
- Random backpressure on `seg_ready` and a random response latency are applied throughout.

// File: rtl/sgw_pkg.sv
// Shared types for the scatter-gather table walker.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sgw_pkg;

    // Completion code reported with done
    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_NO_START  = 2'd1,
        ERR_TOTAL_OVF = 2'd2
    } sgw_err_e;

    // Walker control states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SEG   = 3'd3,
        ST_FIN   = 3'd4
    } sgw_state_e;

endpackage

// File: rtl/sgw_limit.sv
// Effective transfer limit selection.
// Picks either the byte limit (all ones = unlimited) or a sector count
// scaled by the sector size. Purely combinational; assumes the sector
// product fits in LIM_W bits.
module sgw_limit #(
    parameter int LIM_W     = 32,
    parameter int SEC_W     = 8,
    parameter int SEC_SHIFT = 9
) (
    input  logic             use_sectors,
    input  logic [SEC_W-1:0] sect_hi,
    input  logic [SEC_W-1:0] sect_lo,
    input  logic [LIM_W-1:0] byte_limit,
    output logic [LIM_W-1:0] eff_limit,
    output logic             unlimited
);
    localparam int SCNT_W = 2 * SEC_W;

    logic [SCNT_W-1:0] sectors;

    // Sector count from its two bytes
    assign sectors = {sect_hi, sect_lo};

    // Choose the limit source and flag the unlimited encoding
    always_comb begin
        if (use_sectors) begin
            eff_limit = LIM_W'(sectors) << SEC_SHIFT;
            unlimited = 1'b0;
        end else begin
            eff_limit = byte_limit;
            unlimited = &byte_limit;
        end
    end
endmodule

// File: rtl/sgw_fetch.sv
// Entry fetch port: one outstanding read at a time.
// A one-cycle issue from the controller becomes a registered one-cycle
// rd_req. The response is registered and its size field decoded to a
// byte length (field low bits plus one). Responses arriving with no read
// pending are dropped.
module sgw_fetch #(
    parameter int AW    = 48,
    parameter int SZ_W  = 22,
    parameter int CNT_W = 16,
    parameter int FLD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [CNT_W-1:0] idx,
    output logic             rd_req,
    output logic [CNT_W-1:0] rd_idx,
    input  logic             rd_rsp_valid,
    input  logic [AW-1:0]    rd_rsp_addr,
    input  logic [FLD_W-1:0] rd_rsp_size,
    output logic             ent_valid,
    output logic [AW-1:0]    ent_addr,
    output logic [SZ_W:0]    ent_len
);
    localparam int LEN_W = SZ_W + 1;

    logic pending;
    logic unused_size_hi;

    // Upper size-field bits carry no meaning
    assign unused_size_hi = ^rd_rsp_size[FLD_W-1:SZ_W];

    // Request register: one cycle per issue, index held for visibility
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req <= 1'b0;
            rd_idx <= '0;
        end else begin
            rd_req <= issue;
            if (issue) rd_idx <= idx;
        end
    end

    // Outstanding-read tracking
    always_ff @(posedge clk) begin
        if (!rst_n)            pending <= 1'b0;
        else if (issue)        pending <= 1'b1;
        else if (rd_rsp_valid) pending <= 1'b0;
    end

    // Capture and decode the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= 1'b0;
            ent_addr  <= '0;
            ent_len   <= '0;
        end else begin
            ent_valid <= rd_rsp_valid && pending;
            if (rd_rsp_valid && pending) begin
                ent_addr <= rd_rsp_addr;
                ent_len  <= {1'b0, rd_rsp_size[SZ_W-1:0]} + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/sgw_clip.sv
// Segment length clipping and total-overflow detection.
// Given an entry length, an in-entry start position (< length), the bytes
// left before the limit and the bytes emitted so far, returns the
// segment length and whether emitting it would pass MAX_TOTAL.
// Combinational; assumes LEN_W <= ACC_W.
module sgw_clip #(
    parameter int    LEN_W     = 23,
    parameter int    ACC_W     = 33,
    parameter longint MAX_TOTAL = 64'd2147483647
) (
    input  logic [LEN_W-1:0] ent_len,
    input  logic [LEN_W-1:0] pos,
    input  logic [ACC_W-1:0] lim_rem,
    input  logic [ACC_W-1:0] emitted,
    input  logic             unlimited,
    output logic [LEN_W-1:0] seg_len,
    output logic             over_max
);
    logic [LEN_W-1:0] avail;
    logic             clip_it;
    logic [ACC_W:0]   new_total;

    // Bytes left in the entry after the start position
    assign avail = ent_len - pos;

    // Limit clipping unless unlimited
    assign clip_it = !unlimited && (lim_rem < ACC_W'(avail));
    assign seg_len = clip_it ? lim_rem[LEN_W-1:0] : avail;

    // Total after this segment against the ceiling
    assign new_total = {1'b0, emitted} + (ACC_W+1)'(seg_len);
    assign over_max  = new_total > (ACC_W+1)'(MAX_TOTAL);
endmodule

// File: rtl/sg_walker.sv
// Scatter-gather table walker with byte limit.
// On start (idle only) it latches the count, offset and effective limit,
// fetches entries in order through sgw_fetch, skips bytes before the
// offset, and emits clipped segments with valid/ready until the limit is
// met, the table ends, or the running total would pass 2^31-1.
// Results (total, error, short flag) are valid with done and held until
// the next accepted start.
module sg_walker
    import sgw_pkg::*;
#(
    parameter int AW    = 48,
    parameter int SZ_W  = 22,
    parameter int CNT_W = 16,
    parameter int LIM_W = 32,
    parameter int FLD_W = 32,
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] ent_count,
    input  logic [LIM_W-1:0] start_offset,
    input  logic [LIM_W-1:0] byte_limit,
    input  logic             use_sectors,
    input  logic [SEC_W-1:0] sect_hi,
    input  logic [SEC_W-1:0] sect_lo,
    output logic             rd_req,
    output logic [CNT_W-1:0] rd_idx,
    input  logic             rd_rsp_valid,
    input  logic [AW-1:0]    rd_rsp_addr,
    input  logic [FLD_W-1:0] rd_rsp_size,
    output logic             seg_valid,
    input  logic             seg_ready,
    output logic [AW-1:0]    seg_addr,
    output logic [SZ_W:0]    seg_len,
    output logic             done,
    output logic [1:0]       err_code,
    output logic [LIM_W-1:0] total_bytes,
    output logic             short_tbl
);
    localparam int LEN_W = SZ_W + 1;
    localparam int ACC_W = LIM_W + 1;
    localparam int SKW   = (CNT_W + LEN_W > ACC_W) ? CNT_W + LEN_W : ACC_W;

    sgw_state_e        state;
    sgw_err_e          err_q;
    logic [CNT_W-1:0]  idx, count_q;
    logic [LIM_W-1:0]  offset_q, limit_q;
    logic              unlim_q, skipping;
    logic [SKW-1:0]    skip_sum;
    logic [ACC_W-1:0]  emitted;
    logic [AW-1:0]     seg_addr_q;
    logic [LEN_W-1:0]  seg_len_q;

    logic [LIM_W-1:0]  eff_limit;
    logic              eff_unlim;
    logic              ent_valid;
    logic [AW-1:0]     ent_addr;
    logic [LEN_W-1:0]  ent_len;
    logic              hit, last, reaches_lim;
    logic [SKW-1:0]    pos_full;
    logic [LEN_W-1:0]  pos;
    logic [ACC_W-1:0]  lim_rem;
    logic [LEN_W-1:0]  clip_len;
    logic              clip_ovf;
    logic              unused_pos_hi;

    sgw_limit #(.LIM_W(LIM_W), .SEC_W(SEC_W), .SEC_SHIFT(9)) u_limit (
        .use_sectors (use_sectors),
        .sect_hi     (sect_hi),
        .sect_lo     (sect_lo),
        .byte_limit  (byte_limit),
        .eff_limit   (eff_limit),
        .unlimited   (eff_unlim)
    );

    sgw_fetch #(.AW(AW), .SZ_W(SZ_W), .CNT_W(CNT_W), .FLD_W(FLD_W)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (state == ST_FETCH),
        .idx          (idx),
        .rd_req       (rd_req),
        .rd_idx       (rd_idx),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_addr  (rd_rsp_addr),
        .rd_rsp_size  (rd_rsp_size),
        .ent_valid    (ent_valid),
        .ent_addr     (ent_addr),
        .ent_len      (ent_len)
    );

    // Start-entry detection and in-entry position while skipping
    assign hit      = (skip_sum + SKW'(ent_len)) > SKW'(offset_q);
    assign pos_full = SKW'(offset_q) - skip_sum;
    assign pos      = skipping ? pos_full[LEN_W-1:0] : '0;
    assign unused_pos_hi = ^pos_full[SKW-1:LEN_W];

    // Bytes left before the limit, last-entry and limit-reached tests
    assign lim_rem     = {1'b0, limit_q} - emitted;
    assign last        = ({1'b0, idx} + (CNT_W+1)'(1)) == {1'b0, count_q};
    assign reaches_lim = !unlim_q &&
                         ((emitted + ACC_W'(seg_len_q)) == {1'b0, limit_q});

    sgw_clip #(.LEN_W(LEN_W), .ACC_W(ACC_W), .MAX_TOTAL(64'd2147483647)) u_clip (
        .ent_len   (ent_len),
        .pos       (pos),
        .lim_rem   (lim_rem),
        .emitted   (emitted),
        .unlimited (unlim_q),
        .seg_len   (clip_len),
        .over_max  (clip_ovf)
    );

    // Walk controller: start latch, skip phase, emit phase, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            err_q      <= ERR_NONE;
            idx        <= '0;
            count_q    <= '0;
            offset_q   <= '0;
            limit_q    <= '0;
            unlim_q    <= 1'b0;
            skipping   <= 1'b0;
            skip_sum   <= '0;
            emitted    <= '0;
            seg_addr_q <= '0;
            seg_len_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        count_q  <= ent_count;
                        offset_q <= start_offset;
                        limit_q  <= eff_limit;
                        unlim_q  <= eff_unlim;
                        idx      <= '0;
                        skipping <= 1'b1;
                        skip_sum <= '0;
                        emitted  <= '0;
                        err_q    <= ERR_NONE;
                        if (!eff_unlim && eff_limit == '0) begin
                            state <= ST_FIN;
                        end else if (ent_count == '0) begin
                            err_q <= ERR_NO_START;
                            state <= ST_FIN;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state <= ST_WAIT;
                ST_WAIT: begin
                    if (ent_valid) begin
                        if (skipping && !hit) begin
                            skip_sum <= skip_sum + SKW'(ent_len);
                            if (last) begin
                                err_q <= ERR_NO_START;
                                state <= ST_FIN;
                            end else begin
                                idx   <= idx + CNT_W'(1);
                                state <= ST_FETCH;
                            end
                        end else if (clip_ovf) begin
                            err_q <= ERR_TOTAL_OVF;
                            state <= ST_FIN;
                        end else begin
                            seg_addr_q <= ent_addr + AW'(pos);
                            seg_len_q  <= clip_len;
                            skipping   <= 1'b0;
                            state      <= ST_SEG;
                        end
                    end
                end
                ST_SEG: begin
                    if (seg_ready) begin
                        emitted <= emitted + ACC_W'(seg_len_q);
                        if (reaches_lim || last) begin
                            state <= ST_FIN;
                        end else begin
                            idx   <= idx + CNT_W'(1);
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output mapping
    assign seg_valid   = (state == ST_SEG);
    assign seg_addr    = seg_addr_q;
    assign seg_len     = seg_len_q;
    assign done        = (state == ST_FIN);
    assign err_code    = err_q;
    assign total_bytes = emitted[LIM_W-1:0];
    assign short_tbl   = (err_q == ERR_NONE) && !unlim_q &&
                         (emitted < {1'b0, limit_q});
endmodule

// File: rtl/sgw_checks.sv
// Protocol checks for sg_walker, attached by bind below.
// Tracks outstanding reads locally; all properties are reset-qualified.
module sgw_checks #(
    parameter int AW   = 48,
    parameter int SZ_W = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic          rd_rsp_valid,
    input logic          seg_valid,
    input logic          seg_ready,
    input logic [AW-1:0] seg_addr,
    input logic [SZ_W:0] seg_len,
    input logic          done,
    input logic [1:0]    err_code,
    input logic          short_tbl
);
    logic outstanding;

    // Outstanding-read flag from request to response
    always_ff @(posedge clk) begin
        if (!rst_n)            outstanding <= 1'b0;
        else if (rd_req)       outstanding <= 1'b1;
        else if (rd_rsp_valid) outstanding <= 1'b0;
    end

    p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !outstanding);

    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_no_seg_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> !outstanding);

    p_seg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

    p_seg_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_not_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |-> !short_tbl);
endmodule

bind sg_walker sgw_checks #(.AW(AW), .SZ_W(SZ_W)) u_sgw_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .rd_rsp_valid (rd_rsp_valid),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_addr     (seg_addr),
    .seg_len      (seg_len),
    .done         (done),
    .err_code     (err_code),
    .short_tbl    (short_tbl)
);

// File: tb/test_sg_walker.sv
// Bench for sg_walker: behavioural model builds the expected segment
// queue per walk; a table responder with random latency and random
// seg_ready backpressure drives the block; every negedge is compared.
module test_sg_walker;
    localparam int AW = 48;
    localparam int SZ_W = 22;
    localparam int CNT_W = 16;
    localparam int LIM_W = 32;
    localparam longint MASK = 64'h3F_FFFF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] ent_count = '0;
    logic [LIM_W-1:0] start_offset = '0;
    logic [LIM_W-1:0] byte_limit = '0;
    logic             use_sectors = 1'b0;
    logic [7:0]       sect_hi = '0, sect_lo = '0;
    logic             rd_req;
    logic [CNT_W-1:0] rd_idx;
    logic             rd_rsp_valid = 1'b0;
    logic [AW-1:0]    rd_rsp_addr = '0;
    logic [31:0]      rd_rsp_size = '0;
    logic             seg_valid;
    logic             seg_ready = 1'b0;
    logic [AW-1:0]    seg_addr;
    logic [SZ_W:0]    seg_len;
    logic             done;
    logic [1:0]       err_code;
    logic [LIM_W-1:0] total_bytes;
    logic             short_tbl;

    always #4 clk = ~clk;

    sg_walker i_sg_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .ent_count(ent_count),
        .start_offset(start_offset), .byte_limit(byte_limit),
        .use_sectors(use_sectors), .sect_hi(sect_hi), .sect_lo(sect_lo),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_addr(rd_rsp_addr), .rd_rsp_size(rd_rsp_size),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .done(done), .err_code(err_code),
        .total_bytes(total_bytes), .short_tbl(short_tbl)
    );

    logic [AW-1:0] t_addr [0:1023];
    logic [31:0]   t_size [0:1023];

    logic [AW-1:0] q_addr [$];
    longint        q_len  [$];
    longint        exp_total;
    int            exp_err, exp_reads;
    bit            exp_short;
    string         cur_tag = "R13";

    int  n_cmp = 0, n_bad = 0;
    int  reads_seen = 0, next_idx = 0, rsp_cnt = 0, pend_idx = 0;
    bit  pend = 0, got_done = 0, bp_on = 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected segments, totals and read count from the requirements
    task automatic build_expect(int cnt, longint off, longint lim, bit unl);
        longint sum = 0, em = 0, len, l, pos;
        bit found = 0, stop = 0, use_it;
        q_addr.delete(); q_len.delete();
        exp_err = 0; exp_reads = 0;
        if (unl || lim != 0) begin
            for (int i = 0; i < cnt && !stop; i++) begin
                exp_reads = i + 1;
                len = (longint'(t_size[i]) & MASK) + 1;
                use_it = 0; pos = 0;
                if (found) use_it = 1;
                else if (sum + len > off) begin found = 1; use_it = 1; pos = off - sum; end
                else sum += len;
                if (use_it) begin
                    l = len - pos;
                    if (!unl && l > lim - em) l = lim - em;
                    if (em + l > 64'd2147483647) begin exp_err = 2; stop = 1; end
                    else begin
                        q_addr.push_back(t_addr[i] + AW'(pos));
                        q_len.push_back(l);
                        em += l;
                        if (!unl && em == lim) stop = 1;
                    end
                end
            end
            if (!found) exp_err = 1;
        end
        exp_total = em;
        exp_short = (exp_err == 0) && !unl && (em < lim);
    endtask

    // Responder, backpressure and per-clock comparison
    initial begin
        forever begin
            @(negedge clk);
            if (rd_rsp_valid) rd_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_addr  = t_addr[pend_idx];
                    rd_rsp_size  = t_size[pend_idx];
                    pend = 0;
                end
            end
            if (rst_n && rd_req) begin
                check(!pend, "R10", "read while outstanding", 1, 0);
                check(int'(rd_idx) == next_idx, "R10", "read index order", rd_idx, next_idx);
                pend = 1; pend_idx = int'(rd_idx[9:0]); next_idx++; reads_seen++;
                rsp_cnt = 1 + int'($urandom % 3);
            end
            seg_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
            if (rst_n && seg_valid && seg_ready) begin
                if (q_addr.size() == 0) begin
                    check(0, cur_tag, "unexpected segment len", seg_len, 0);
                end else begin
                    check(seg_addr == q_addr[0], cur_tag, "segment address", seg_addr, q_addr[0]);
                    check(longint'(seg_len) == q_len[0], cur_tag, "segment length", seg_len, q_len[0]);
                    void'(q_addr.pop_front()); void'(q_len.pop_front());
                end
            end
            if (rst_n && done) begin
                check(int'(err_code) == exp_err, cur_tag, "error code", err_code, exp_err);
                check(longint'(total_bytes) == exp_total, cur_tag, "total bytes", total_bytes, exp_total);
                check(short_tbl == exp_short, cur_tag, "short flag", short_tbl, exp_short);
                check(q_addr.size() == 0, cur_tag, "segments missing", q_addr.size(), 0);
                got_done = 1;
            end
        end
    end

    // One walk; poke issues an extra start mid-walk that must be ignored
    task automatic run(string tag, int cnt, longint off, longint lim,
                       bit bysec, int hi, int lo, bit poke);
        longint eff;
        int t = 0;
        bit unl;
        eff = bysec ? longint'({hi[7:0], lo[7:0]}) * 512 : lim;
        unl = !bysec && (lim == 64'hFFFF_FFFF);
        build_expect(cnt, off, eff, unl);
        cur_tag = tag;
        next_idx = 0; reads_seen = 0; got_done = 0;
        @(negedge clk);
        ent_count = CNT_W'(cnt); start_offset = LIM_W'(off); byte_limit = LIM_W'(lim);
        use_sectors = bysec; sect_hi = 8'(hi); sect_lo = 8'(lo); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            ent_count = '0; start_offset = '1; byte_limit = 32'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!got_done && t < 50000) begin @(negedge clk); t++; end
        check(got_done, tag, "walk finished", got_done, 1);
        @(negedge clk);
        check(reads_seen == exp_reads, tag, "entry reads", reads_seen, exp_reads);
        check(!done, "R13", "done is one cycle", done, 0);
    endtask

    task automatic set_ent(int i, longint a, longint fld);
        t_addr[i] = AW'(a);
        t_size[i] = 32'(fld);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "R13", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) set_ent(i, 64'h1000 * i, 0);
        repeat (4) @(negedge clk);
        // R13: reset state
        check(!seg_valid && !done && !rd_req, "R13", "reset controls", {seg_valid, done, rd_req}, 0);
        check(total_bytes == 0 && err_code == 0 && !short_tbl, "R13", "reset results", total_bytes, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R3/R4: garbage upper size bits, limit ends inside third entry
        for (int i = 0; i < 4; i++) set_ent(i, 64'h10_0000 + 64'h4000 * i, 64'hABC0_03FF);
        run("R1", 4, 0, 3000, 0, 0, 0, 0);
        run("R4", 4, 500, 1000, 0, 0, 0, 0);

        // R2/R6: offset exactly on an entry boundary, unlimited
        set_ent(0, 64'h2000, 99); set_ent(1, 64'h5000, 199); set_ent(2, 64'h9000, 299);
        run("R2", 3, 100, 64'hFFFF_FFFF, 0, 0, 0, 0);
        run("R6", 3, 0, 64'hFFFF_FFFF, 0, 0, 0, 0);
        // R3: mid-entry start, limit inside that entry
        run("R3", 3, 150, 100, 0, 0, 0, 0);
        // R5: table shorter than limit
        run("R5", 3, 20, 10000, 0, 0, 0, 0);
        // R9: offset at table end, and zero count
        run("R9", 3, 600, 5000, 0, 0, 0, 0);
        run("R9", 0, 0, 5000, 0, 0, 0, 0);
        // R12: zero limit
        run("R12", 3, 0, 0, 0, 0, 0, 0);

        // R7: sector-count limits
        for (int i = 0; i < 4; i++) set_ent(i, 64'h40_0000 * (i + 1), 1023);
        run("R7", 4, 0, 64'hFFFF_FFFF, 1, 0, 3, 0);
        for (int i = 0; i < 4; i++) set_ent(i, 64'h80_0000 * (i + 1), 65535);
        run("R7", 4, 0, 5, 1, 1, 0, 0);

        // R13: start during a walk is ignored
        for (int i = 0; i < 8; i++) set_ent(i, 64'h30_0000 + 64'h100 * i, 63);
        run("R13", 8, 10, 64'hFFFF_FFFF, 0, 0, 0, 1);

        // R11/R10: no backpressure variant, then randomised walks
        bp_on = 0;
        run("R11", 8, 0, 300, 0, 0, 0, 0);
        bp_on = 1;
        for (int k = 0; k < 20; k++) begin
            int cnt, mode;
            longint sum = 0, off, lim;
            cnt = 1 + int'($urandom % 8);
            for (int i = 0; i < cnt; i++) begin
                set_ent(i, longint'($urandom) * 16, (longint'($urandom % 8) << 28) | longint'($urandom % 300));
                sum += (longint'(t_size[i]) & MASK) + 1;
            end
            off = longint'($urandom) % (sum + 50);
            mode = int'($urandom % 3);
            lim = (mode == 0) ? 64'hFFFF_FFFF : (1 + longint'($urandom % 1500));
            if (mode == 2) run("R4", cnt, off, 0, 1, 0, int'($urandom % 3), 0);
            else           run("R4", cnt, off, lim, 0, 0, 0, 0);
        end

        // R8: total would pass 2^31-1
        for (int i = 0; i < 600; i++) set_ent(i, 64'h1_0000_0000 + 64'h40_0000 * i, 64'hFFFF_FFFF);
        run("R8", 600, 0, 64'hFFFF_FFFF, 0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule